// File: doc/BRIEF.md
# Producer Re-execute Suppression Table

This block sits at the commit end of a core that runs a redundant copy of its main thread. Each in-flight main-thread instruction owns one bit in a re-execute vector. A bit that stays set means that the redundant copy of the instruction still has to run. A committing instruction whose result passed validation must not be re-run. The block also suppresses re-execution of the instructions that produced that instruction's operands, because a correct consumer result makes a faulty producer very unlikely.

To find those producers, the block keeps one entry per architectural register. Each entry holds the vector index of the last committed instruction that wrote the register, together with a valid flag. On a validated commit, the block clears three bits in the same cycle: the instruction's own bit and the bits named by the entries of its two source registers. The allocation side sets a bit whenever an index is handed to a new instruction. A pipeline flush empties the table. Any vector bit can be read through a combinational query port.

Top module: `prod_suppress_table`

## Requirements
- R1: After reset every vector bit reads 0 and every table entry is invalid, so a validated commit clears no bit other than its own.
- R2: When `alloc_vld_i` is 1, the bit at `alloc_idx_i` reads 1 after the next rising clock edge.
- R3: If one index is both allocated and targeted by any clear in the same cycle, the set wins and the bit reads 1 afterwards.
- R4: A commit with `cmt_dst_vld_i` = 1 stores `cmt_idx_i` as the producer of register `cmt_dst_i` and marks that entry valid, whether or not its validation succeeded.
- R5: A commit with `cmt_val_ok_i` = 1 clears the bit at `cmt_idx_i` at the next edge.
- R6: In that same edge, for each source whose select is 1 and whose table entry is valid, the bit at the stored producer index is cleared; both sources can clear in one cycle.
- R7: A commit with `cmt_val_ok_i` = 0 clears no bit at all, neither its own nor its producers'.
- R8: A source whose select is 0, or whose table entry is invalid, clears no bit.
- R9: Sources are looked up in the table before the same cycle's destination write, so an instruction that reads and writes one register clears the older producer.
- R10: `flush_i` invalidates every table entry at the next edge and drops a destination write made in the same cycle. The clears of a commit in that cycle still use the table contents from before the flush.
- R11: `qry_bit_o` shows the current value of the bit at `qry_idx_i` without a clock delay, and updates are visible right after the edge that makes them.
- R12: A commit with `cmt_dst_vld_i` = 0 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Invalidate all producer entries |
| alloc_vld_i | input | 1 | Set the bit of a newly allocated index |
| alloc_idx_i | input | 6 | Index being allocated |
| cmt_vld_i | input | 1 | A main-thread instruction commits this cycle |
| cmt_idx_i | input | 6 | Vector index of the committing instruction |
| cmt_val_ok_i | input | 1 | Its result passed validation |
| cmt_dst_vld_i | input | 1 | It writes a destination register |
| cmt_dst_i | input | 5 | Destination register |
| cmt_src0_vld_i | input | 1 | First source operand is a register |
| cmt_src0_i | input | 5 | First source register |
| cmt_src1_vld_i | input | 1 | Second source operand is a register |
| cmt_src1_i | input | 5 | Second source register |
| qry_idx_i | input | 6 | Index to read |
| qry_bit_o | output | 1 | Current bit at `qry_idx_i` |

## Verification
The bench builds the block with its default sizes: 32 registers and a 64-bit vector. With these sizes every register and every index can be reached from random stimulus. In half of the random cycles the indices and registers are drawn from a narrow band of eight values. This makes a set and a clear land on one index, a source and its destination name one register, and a flush coincide with a commit far more often than uniform draws would. Directed sequences build the producer chains that R6, R9, R10 and R12 depend on before the random phase starts.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int unsigned PST_NUM_AREGS = 32;
  localparam int unsigned PST_VEC_BITS  = 64;

  typedef enum logic [1:0] {
    BIT_HOLD  = 2'd0,
    BIT_CLEAR = 2'd1,
    BIT_SET   = 2'd2
  } bit_act_t;
endpackage

// File: rtl/pst_rst_sync.sv
module pst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pst_index_table.sv
module pst_index_table #(
  parameter int unsigned NUM_AREGS = 32,
  parameter int unsigned IDX_W     = 6,
  localparam int unsigned AREG_W   = $clog2(NUM_AREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic                 wr_en_i,
  input  logic [AREG_W-1:0]    wr_reg_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [AREG_W-1:0]    rd0_reg_i,
  input  logic [AREG_W-1:0]    rd1_reg_i,
  output logic                 rd0_vld_o,
  output logic [IDX_W-1:0]     rd0_idx_o,
  output logic                 rd1_vld_o,
  output logic [IDX_W-1:0]     rd1_idx_o,
  output logic [NUM_AREGS-1:0] vld_o
);
  logic [NUM_AREGS-1:0] vld_q;
  logic [NUM_AREGS-1:0] vld_d;
  logic [NUM_AREGS-1:0] ent_we;
  logic [IDX_W-1:0]     idx_q [NUM_AREGS];

  // write decode: a flush suppresses the destination write
  always_comb begin
    for (int e = 0; e < NUM_AREGS; e++) begin
      ent_we[e] = wr_en_i && !flush_i && (wr_reg_i == AREG_W'(e));
    end
  end

  always_comb begin
    if (flush_i) vld_d = '0;
    else         vld_d = vld_q | ent_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_AREGS; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         idx_q[g] <= '0;
        else if (ent_we[g]) idx_q[g] <= wr_idx_i;
      end
    end
  endgenerate

  // reads see the registered contents: older producer wins over this cycle's write
  assign rd0_vld_o = vld_q[rd0_reg_i];
  assign rd0_idx_o = idx_q[rd0_reg_i];
  assign rd1_vld_o = vld_q[rd1_reg_i];
  assign rd1_idx_o = idx_q[rd1_reg_i];
  assign vld_o     = vld_q;
endmodule

// File: rtl/pst_clear_decode.sv
module pst_clear_decode #(
  parameter int unsigned VEC_BITS = 64,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned NREQ     = 3
) (
  input  logic [NREQ-1:0]  req_vld_i,
  input  logic [IDX_W-1:0] req_idx_i [NREQ],
  output logic [VEC_BITS-1:0] clr_mask_o
);
  always_comb begin
    clr_mask_o = '0;
    for (int b = 0; b < VEC_BITS; b++) begin
      for (int r = 0; r < NREQ; r++) begin
        if (req_vld_i[r] && (req_idx_i[r] == IDX_W'(b))) clr_mask_o[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pst_reexec_vec.sv
module pst_reexec_vec
  import pst_pkg::*;
#(
  parameter int unsigned VEC_BITS = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic [VEC_BITS-1:0] clr_mask_i,
  input  logic [IDX_W-1:0]    qry_idx_i,
  output logic                qry_bit_o,
  output logic [VEC_BITS-1:0] bits_o
);
  bit_act_t            act [VEC_BITS];
  logic [VEC_BITS-1:0] bits_q;

  // per-bit action; set takes priority over clear
  always_comb begin
    for (int b = 0; b < VEC_BITS; b++) begin
      if (set_en_i && (set_idx_i == IDX_W'(b))) act[b] = BIT_SET;
      else if (clr_mask_i[b])                   act[b] = BIT_CLEAR;
      else                                      act[b] = BIT_HOLD;
    end
  end

  genvar g;
  generate
    for (g = 0; g < VEC_BITS; g++) begin : g_bit
      logic bit_en;
      logic bit_d;
      always_comb begin
        bit_en = (act[g] != BIT_HOLD);
        bit_d  = (act[g] == BIT_SET);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bits_q[g] <= 1'b0;
        else if (bit_en) bits_q[g] <= bit_d;
      end
    end
  endgenerate

  assign qry_bit_o = bits_q[qry_idx_i];
  assign bits_o    = bits_q;
endmodule

// File: rtl/prod_suppress_table.sv
module prod_suppress_table
  import pst_pkg::*;
#(
  parameter int unsigned NUM_AREGS = PST_NUM_AREGS,
  parameter int unsigned VEC_BITS  = PST_VEC_BITS,
  localparam int unsigned AREG_W   = $clog2(NUM_AREGS),
  localparam int unsigned IDX_W    = $clog2(VEC_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_vld_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic              cmt_vld_i,
  input  logic [IDX_W-1:0]  cmt_idx_i,
  input  logic              cmt_val_ok_i,
  input  logic              cmt_dst_vld_i,
  input  logic [AREG_W-1:0] cmt_dst_i,
  input  logic              cmt_src0_vld_i,
  input  logic [AREG_W-1:0] cmt_src0_i,
  input  logic              cmt_src1_vld_i,
  input  logic [AREG_W-1:0] cmt_src1_i,
  input  logic [IDX_W-1:0]  qry_idx_i,
  output logic              qry_bit_o
);
  localparam int unsigned NREQ = 3;

  logic                 rst_sync_n;
  logic                 p0_vld, p1_vld;
  logic [IDX_W-1:0]     p0_idx, p1_idx;
  logic [NUM_AREGS-1:0] tbl_vld;
  logic                 cmt_ok;
  logic                 tbl_we;
  logic [NREQ-1:0]      clr_vld;
  logic [IDX_W-1:0]     clr_idx [NREQ];
  logic [VEC_BITS-1:0]  clr_mask;
  logic [VEC_BITS-1:0]  reexec_q;

  pst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  always_comb begin
    cmt_ok     = cmt_vld_i && cmt_val_ok_i;
    tbl_we     = cmt_vld_i && cmt_dst_vld_i;
    clr_vld[0] = cmt_ok;
    clr_idx[0] = cmt_idx_i;
    clr_vld[1] = cmt_ok && cmt_src0_vld_i && p0_vld;
    clr_idx[1] = p0_idx;
    clr_vld[2] = cmt_ok && cmt_src1_vld_i && p1_vld;
    clr_idx[2] = p1_idx;
  end

  pst_index_table #(.NUM_AREGS(NUM_AREGS), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush_i   (flush_i),
    .wr_en_i   (tbl_we),
    .wr_reg_i  (cmt_dst_i),
    .wr_idx_i  (cmt_idx_i),
    .rd0_reg_i (cmt_src0_i),
    .rd1_reg_i (cmt_src1_i),
    .rd0_vld_o (p0_vld),
    .rd0_idx_o (p0_idx),
    .rd1_vld_o (p1_vld),
    .rd1_idx_o (p1_idx),
    .vld_o     (tbl_vld)
  );

  pst_clear_decode #(.VEC_BITS(VEC_BITS), .IDX_W(IDX_W), .NREQ(NREQ)) u_clr (
    .req_vld_i  (clr_vld),
    .req_idx_i  (clr_idx),
    .clr_mask_o (clr_mask)
  );

  pst_reexec_vec #(.VEC_BITS(VEC_BITS), .IDX_W(IDX_W)) u_vec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_en_i   (alloc_vld_i),
    .set_idx_i  (alloc_idx_i),
    .clr_mask_i (clr_mask),
    .qry_idx_i  (qry_idx_i),
    .qry_bit_o  (qry_bit_o),
    .bits_o     (reexec_q)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int unsigned NUM_AREGS = 32,
  parameter int unsigned VEC_BITS  = 64,
  parameter int unsigned IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush_i,
  input logic                 alloc_vld_i,
  input logic [IDX_W-1:0]     alloc_idx_i,
  input logic                 cmt_vld_i,
  input logic [IDX_W-1:0]     cmt_idx_i,
  input logic                 cmt_val_ok_i,
  input logic                 cmt_src0_vld_i,
  input logic                 p0_vld,
  input logic [IDX_W-1:0]     p0_idx,
  input logic [NUM_AREGS-1:0] tbl_vld,
  input logic [VEC_BITS-1:0]  reexec_q
);
  // R2
  alloc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld_i |=> reexec_q[$past(alloc_idx_i)]);

  // R5
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld_i && cmt_val_ok_i && !(alloc_vld_i && alloc_idx_i == cmt_idx_i))
    |=> !reexec_q[$past(cmt_idx_i)]);

  // R6
  producer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld_i && cmt_val_ok_i && cmt_src0_vld_i && p0_vld &&
     !(alloc_vld_i && alloc_idx_i == p0_idx))
    |=> !reexec_q[$past(p0_idx)]);

  // R7
  no_clear_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmt_vld_i && cmt_val_ok_i) && !alloc_vld_i) |=> $stable(reexec_q));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (tbl_vld == '0));
endmodule

bind prod_suppress_table pst_checker #(
  .NUM_AREGS (NUM_AREGS),
  .VEC_BITS  (VEC_BITS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .flush_i        (flush_i),
  .alloc_vld_i    (alloc_vld_i),
  .alloc_idx_i    (alloc_idx_i),
  .cmt_vld_i      (cmt_vld_i),
  .cmt_idx_i      (cmt_idx_i),
  .cmt_val_ok_i   (cmt_val_ok_i),
  .cmt_src0_vld_i (cmt_src0_vld_i),
  .p0_vld         (p0_vld),
  .p0_idx         (p0_idx),
  .tbl_vld        (tbl_vld),
  .reexec_q       (reexec_q)
);

// File: tb/prod_suppress_table_tb.sv
module prod_suppress_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int NBIT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush_i = 0, alloc_vld_i = 0, cmt_vld_i = 0, cmt_val_ok_i = 0;
  logic       cmt_dst_vld_i = 0, cmt_src0_vld_i = 0, cmt_src1_vld_i = 0;
  logic [5:0] alloc_idx_i = 0, cmt_idx_i = 0, qry_idx_i = 0;
  logic [4:0] cmt_dst_i = 0, cmt_src0_i = 0, cmt_src1_i = 0;
  logic       qry_bit_o;

  int n_checks = 0;
  int n_fails  = 0;

  logic            m_vld [NREG];
  logic [5:0]      m_idx [NREG];
  logic [NBIT-1:0] m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  prod_suppress_table u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .alloc_vld_i(alloc_vld_i), .alloc_idx_i(alloc_idx_i),
    .cmt_vld_i(cmt_vld_i), .cmt_idx_i(cmt_idx_i), .cmt_val_ok_i(cmt_val_ok_i),
    .cmt_dst_vld_i(cmt_dst_vld_i), .cmt_dst_i(cmt_dst_i),
    .cmt_src0_vld_i(cmt_src0_vld_i), .cmt_src0_i(cmt_src0_i),
    .cmt_src1_vld_i(cmt_src1_vld_i), .cmt_src1_i(cmt_src1_i),
    .qry_idx_i(qry_idx_i), .qry_bit_o(qry_bit_o)
  );

  task automatic check(string req, logic got, logic exp, int idx);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s bit %0d: actual %0b expected %0b", req, idx, got, exp);
    end
  endtask

  // reads one bit through the query port (R11)
  task automatic probe(string req, logic [5:0] idx);
    qry_idx_i = idx;
    #1;
    check(req, qry_bit_o, m_vec[idx], idx);
  endtask

  // full sweep while inputs are idle
  task automatic sweep(string req);
    int bad = -1;
    logic got_b = 1'b0;
    for (int b = 0; b < NBIT; b++) begin
      qry_idx_i = 6'(b);
      #1;
      if (qry_bit_o !== m_vec[b] && bad < 0) begin
        bad = b;
        got_b = qry_bit_o;
      end
    end
    n_checks++;
    if (bad >= 0) begin
      n_fails++;
      $display("FAIL %s sweep bit %0d: actual %0b expected %0b", req, bad, got_b, m_vec[bad]);
    end
  endtask

  // one clock of stimulus; the model is advanced at the edge, then probed
  task automatic step(logic av, logic [5:0] ai, logic cv, logic [5:0] ci, logic ok,
                      logic dv, logic [4:0] d, logic s0v, logic [4:0] s0,
                      logic s1v, logic [4:0] s1, logic fl);
    logic [NBIT-1:0] nvec;
    logic            p0v, p1v;
    logic [5:0]      p0i, p1i;
    alloc_vld_i = av; alloc_idx_i = ai; cmt_vld_i = cv; cmt_idx_i = ci;
    cmt_val_ok_i = ok; cmt_dst_vld_i = dv; cmt_dst_i = d;
    cmt_src0_vld_i = s0v; cmt_src0_i = s0; cmt_src1_vld_i = s1v; cmt_src1_i = s1;
    flush_i = fl;
    p0v = s0v && m_vld[s0]; p0i = m_idx[s0];
    p1v = s1v && m_vld[s1]; p1i = m_idx[s1];
    nvec = m_vec;
    if (cv && ok) begin
      nvec[ci] = 1'b0;              // R5
      if (p0v) nvec[p0i] = 1'b0;    // R6, R8, R9
      if (p1v) nvec[p1i] = 1'b0;
    end
    if (av) nvec[ai] = 1'b1;        // R2, R3
    @(posedge clk);
    m_vec = nvec;
    if (fl) begin
      for (int r = 0; r < NREG; r++) m_vld[r] = 1'b0;   // R10
    end else if (cv && dv) begin                          // R4, R12
      m_vld[d] = 1'b1;
      m_idx[d] = ci;
    end
    #1;
    if (av) probe("R2", ai);
    if (cv) probe(ok ? "R5" : "R7", ci);
    if (cv && p0v) probe(ok ? "R6" : "R7", p0i);
    if (cv && p1v) probe(ok ? "R6" : "R7", p1i);
    alloc_vld_i = 0; cmt_vld_i = 0; flush_i = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int r = 0; r < NREG; r++) begin m_vld[r] = 0; m_idx[r] = 0; end
    m_vec = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    sweep("R1");
    // R1: validated commit with sources on never-written registers clears only itself
    step(1, 6'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd6, 1, 0, 0, 1, 5'd3, 1, 5'd7, 0);
    sweep("R1");
    // R2, R4, R7: producers committed with failing validation
    for (int k = 10; k < 14; k++) step(1, 6'(k), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd10, 0, 1, 5'd3, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd11, 0, 1, 5'd4, 0, 0, 0, 0, 0);
    sweep("R7");
    // R5, R6: validated consumer clears itself and both producers
    step(0, 0, 1, 6'd12, 1, 1, 5'd5, 1, 5'd3, 1, 5'd4, 0);
    sweep("R6");
    // R3: set wins over producer clear on the same index
    step(1, 6'd20, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd21, 1, 6'd20, 0, 1, 5'd6, 0, 0, 0, 0, 0);
    step(1, 6'd20, 1, 6'd21, 1, 0, 0, 1, 5'd6, 0, 0, 0);
    sweep("R3");
    // R8: unselected source and invalid-entry source clear nothing
    step(1, 6'd30, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd31, 1, 6'd30, 0, 1, 5'd7, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd31, 1, 0, 0, 0, 5'd7, 1, 5'd9, 0);
    sweep("R8");
    // R9: same register as source and destination points at the older producer
    step(1, 6'd40, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd41, 1, 6'd40, 0, 1, 5'd8, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd41, 1, 1, 5'd8, 1, 5'd8, 0, 0, 0);
    step(1, 6'd41, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd42, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd42, 1, 0, 0, 1, 5'd8, 0, 0, 0);
    sweep("R9");
    // R12: commit without destination leaves the table alone
    step(1, 6'd41, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd43, 1, 6'd43, 0, 0, 5'd8, 0, 0, 0, 0, 0);
    step(1, 6'd44, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd44, 1, 0, 0, 1, 5'd8, 0, 0, 0);
    sweep("R12");
    // R10: flush with a same-cycle commit
    step(1, 6'd50, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd51, 1, 6'd50, 0, 1, 5'd10, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd51, 1, 1, 5'd11, 1, 5'd10, 0, 0, 1);
    step(1, 6'd50, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd51, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 6'd52, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 6'd52, 1, 0, 0, 1, 5'd10, 1, 5'd11, 0);
    sweep("R10");
    // random phase, R11 probes of an arbitrary bit each cycle
    for (int n = 0; n < 3000; n++) begin
      logic nar;
      logic [5:0] ai, ci;
      logic [4:0] d, s0, s1;
      nar = ($urandom_range(0, 1) == 0);
      ai = nar ? 6'($urandom_range(0, 7)) : 6'($urandom_range(0, 63));
      ci = nar ? 6'($urandom_range(0, 7)) : 6'($urandom_range(0, 63));
      d  = nar ? 5'($urandom_range(0, 7)) : 5'($urandom_range(0, 31));
      s0 = nar ? 5'($urandom_range(0, 7)) : 5'($urandom_range(0, 31));
      s1 = nar ? 5'($urandom_range(0, 7)) : 5'($urandom_range(0, 31));
      step(1'($urandom_range(0, 1)), ai, 1'($urandom_range(0, 1)), ci,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), d,
           1'($urandom_range(0, 3) != 0), s0, 1'($urandom_range(0, 3) != 0), s1,
           1'($urandom_range(0, 49) == 0));
      probe("R11", 6'($urandom_range(0, 63)));
    end
    idle();
    sweep("R11");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule